// File: doc/BRIEF.md
# Eight-Input Fixed-Priority Interrupt Controller

This block gathers up to eight edge-signalled interrupt requests and raises one interrupt line toward a processor. The processor programs it through a byte-wide register port that has a single address bit. A write to the even address with bit 4 set starts an initialization sequence. The odd-address writes that follow set the vector base, an optional cascade configuration byte and an optional mode byte. Once initialization is complete, odd-address writes load the interrupt mask. Even-address writes then act as commands: end-of-interrupt (specific or non-specific) and selection of the register that even-address reads return.

The processor answers the interrupt line with two pulses on the acknowledge input. On the rising edge of the first pulse, the controller picks the highest-priority eligible request. It marks that request in service and clears its request bit. During the second pulse the controller presents the 8-bit vector. The vector is qualified by `vec_valid` and takes no back-pressure: `vec_valid` stays high until the controller sees the acknowledge input fall, so the processor samples the vector while it holds the pulse high. If the request has been withdrawn before the first pulse, a spurious vector for the lowest-priority level is returned and no in-service bit is set. In auto end-of-interrupt mode, the in-service bit clears when the second pulse ends. The cascade byte is passed to the surrounding logic unchanged. A master treats it as a bit mask of inputs that have slaves attached. A slave treats its low three bits as its own identity.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF at the odd address, the request and in-service registers are zero, the even address returns the request register, and `int_out` and `vec_valid` are low.
- R2: An even-address write with bit 4 set clears the mask, request and in-service registers, selects request-register readback and turns auto end-of-interrupt off. The next odd-address write is the vector base. If bit 1 of that command was 0, the following odd write is the cascade byte. If bit 0 was 1, the next odd write is the mode byte. Any later odd write loads the mask.
- R3: The vector equals the upper five bits of the vector base followed by the 3-bit level, so a base of 0x08 maps levels 0..7 onto 0x08..0x0F.
- R4: The cascade byte from the initialization sequence appears unchanged on `cascade_cfg`.
- R5: Outside the initialization sequence, an odd-address write loads the mask and an odd-address read returns it. A set mask bit keeps its input from raising `int_out`.
- R6: A rising edge on an input sets its request bit. The bit clears when the input falls or when that level is taken by the first acknowledge pulse.
- R7: Level 0 has the highest priority. `int_out` is high when some unmasked request has a level numerically lower than every set in-service bit, and the first acknowledge pulse takes the lowest such level.
- R8: The first rising edge of `int_ack` sets the winner's in-service bit. After the second rising edge, `vec_valid` is high and `vec_out` holds the vector until `int_ack` falls.
- R9: If no request is eligible at the first pulse, the vector carries level 7 and no in-service bit changes.
- R10: An even-address write of 0x0A makes even reads return the request register, and a write of 0x0B makes them return the in-service register. The choice persists until it is changed.
- R11: An even-address write of 0x60+n clears in-service bit n and no other bit.
- R12: An even-address write of 0x20 clears only the lowest-numbered set in-service bit.
- R13: When bit 1 of the mode byte is 1, the in-service bit taken by an acknowledge clears when the second pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 1 | Register address bit: 0 even, 1 odd |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current address |
| irq_in | input | 8 | Interrupt request inputs, level 0 highest |
| int_out | output | 1 | Interrupt line to the processor |
| int_ack | input | 1 | Acknowledge pulses from the processor |
| vec_valid | output | 1 | Vector qualifier during the second pulse |
| vec_out | output | 8 | Interrupt vector |
| cascade_cfg | output | 8 | Cascade configuration byte |

## Verification
The bench builds the controller with its default of eight inputs. This makes level 7 the spurious level and gives the vector base five significant bits. With these values, every input, the full priority nesting from level 1 under level 2 down to level 6, and the spurious path with its 0x0F and 0x27 vectors can each be driven directly. Two initialization sequences are run: a four-write sequence with normal end-of-interrupt, and a shorter single-controller sequence with auto end-of-interrupt. Between them, both the skipped and the taken cascade step are covered.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    CFG_RUN,
    CFG_BASE,
    CFG_CASC,
    CFG_MODE
  } cfg_st_e;

  typedef enum logic [1:0] {
    ACK_IDLE,
    ACK_ONE,
    ACK_TWO
  } ack_st_e;

  localparam logic [2:0] OP_EOI_ANY  = 3'b001;
  localparam logic [2:0] OP_EOI_LVL  = 3'b011;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  localparam int unsigned LVL_W = $clog2(NUM_IRQ)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic                     reg_addr,
  input  logic [NUM_IRQ-1:0]       reg_wdata,
  output logic [NUM_IRQ-1:0]       imr,
  output logic [NUM_IRQ-LVL_W-1:0] base_hi,
  output logic [NUM_IRQ-1:0]       casc,
  output logic                     aeoi,
  output logic                     rd_isr,
  output logic                     init_go,
  output logic                     eoi_spec,
  output logic                     eoi_any,
  output logic [LVL_W-1:0]         eoi_lvl
);
  cfg_st_e st;
  logic    want_casc;
  logic    want_mode;
  logic    cmd_wr;
  logic    ocw_wr;

  assign cmd_wr   = reg_wr && !reg_addr;
  assign init_go  = cmd_wr && reg_wdata[4];
  assign ocw_wr   = cmd_wr && !reg_wdata[4] && !reg_wdata[3];
  assign eoi_spec = ocw_wr && (reg_wdata[7:5] == OP_EOI_LVL);
  assign eoi_any  = ocw_wr && (reg_wdata[7:5] == OP_EOI_ANY);
  assign eoi_lvl  = reg_wdata[LVL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= CFG_RUN;
      imr       <= '1;
      base_hi   <= '0;
      casc      <= '0;
      aeoi      <= 1'b0;
      rd_isr    <= 1'b0;
      want_casc <= 1'b0;
      want_mode <= 1'b0;
    end else if (init_go) begin
      st        <= CFG_BASE;
      imr       <= '0;
      rd_isr    <= 1'b0;
      aeoi      <= 1'b0;
      want_casc <= ~reg_wdata[1];
      want_mode <= reg_wdata[0];
    end else if (cmd_wr) begin
      if (reg_wdata[3] && reg_wdata[1]) rd_isr <= reg_wdata[0];
    end else if (reg_wr) begin
      unique case (st)
        CFG_BASE: begin
          base_hi <= reg_wdata[NUM_IRQ-1:LVL_W];
          st      <= want_casc ? CFG_CASC : (want_mode ? CFG_MODE : CFG_RUN);
        end
        CFG_CASC: begin
          casc <= reg_wdata;
          st   <= want_mode ? CFG_MODE : CFG_RUN;
        end
        CFG_MODE: begin
          aeoi <= reg_wdata[1];
          st   <= CFG_RUN;
        end
        default: imr <= reg_wdata;
      endcase
    end
  end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int unsigned NUM_IRQ = 8,
  localparam int unsigned LVL_W = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               init_go,
  input  logic               clr_en,
  input  logic [LVL_W-1:0]   clr_lvl,
  output logic [NUM_IRQ-1:0] irr
);
  logic [NUM_IRQ-1:0] irq_q;
  logic [NUM_IRQ-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    if (clr_en) clr_vec[clr_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      irr   <= '0;
    end else begin
      irq_q <= irq_in;
      if (init_go) irr <= '0;
      else         irr <= (irr | (irq_in & ~irq_q)) & irq_in & ~clr_vec;
    end
  end
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve #(
  parameter int unsigned NUM_IRQ = 8,
  localparam int unsigned LVL_W = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] irr,
  input  logic [NUM_IRQ-1:0] imr,
  input  logic [NUM_IRQ-1:0] isr,
  output logic               any_elig,
  output logic [LVL_W-1:0]   win_lvl,
  output logic               isr_any,
  output logic [LVL_W-1:0]   isr_low
);
  logic [NUM_IRQ-1:0] elig;
  int unsigned        top;

  always_comb begin
    top     = NUM_IRQ;
    isr_low = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (isr[i]) begin
        top     = i;
        isr_low = LVL_W'(i);
      end
    end
    isr_any = |isr;
    for (int i = 0; i < NUM_IRQ; i++) begin
      elig[i] = irr[i] && !imr[i] && (i < top);
    end
    any_elig = |elig;
    win_lvl  = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (elig[i]) win_lvl = LVL_W'(i);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [NUM_IRQ-1:0] reg_wdata,
  output logic [NUM_IRQ-1:0] reg_rdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic               int_out,
  input  logic               int_ack,
  output logic               vec_valid,
  output logic [NUM_IRQ-1:0] vec_out,
  output logic [NUM_IRQ-1:0] cascade_cfg
);
  localparam int unsigned LVL_W = $clog2(NUM_IRQ);

  logic [NUM_IRQ-1:0]       imr_q;
  logic [NUM_IRQ-LVL_W-1:0] base_hi;
  logic                     aeoi_q;
  logic                     rd_isr;
  logic                     init_go;
  logic                     eoi_spec;
  logic                     eoi_any;
  logic [LVL_W-1:0]         eoi_lvl;
  logic [NUM_IRQ-1:0]       irr_q;
  logic [NUM_IRQ-1:0]       isr_q;
  logic [NUM_IRQ-1:0]       isr_n;
  logic                     any_elig;
  logic [LVL_W-1:0]         win_lvl;
  logic                     isr_any;
  logic [LVL_W-1:0]         isr_low;
  logic                     ack_q;
  logic                     ack_rise;
  logic                     ack_fall;
  logic                     take;
  logic                     auto_clr;
  ack_st_e                  ack_st;
  logic [LVL_W-1:0]         lvl_q;
  logic                     spur_q;

  pic_cfg_regs #(.NUM_IRQ(NUM_IRQ)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .imr      (imr_q),
    .base_hi  (base_hi),
    .casc     (cascade_cfg),
    .aeoi     (aeoi_q),
    .rd_isr   (rd_isr),
    .init_go  (init_go),
    .eoi_spec (eoi_spec),
    .eoi_any  (eoi_any),
    .eoi_lvl  (eoi_lvl)
  );

  pic_req_latch #(.NUM_IRQ(NUM_IRQ)) u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_in (irq_in),
    .init_go(init_go),
    .clr_en (take && any_elig),
    .clr_lvl(win_lvl),
    .irr    (irr_q)
  );

  pic_prio_resolve #(.NUM_IRQ(NUM_IRQ)) u_res (
    .irr     (irr_q),
    .imr     (imr_q),
    .isr     (isr_q),
    .any_elig(any_elig),
    .win_lvl (win_lvl),
    .isr_any (isr_any),
    .isr_low (isr_low)
  );

  assign ack_rise = int_ack && !ack_q;
  assign ack_fall = !int_ack && ack_q;
  assign take     = (ack_st == ACK_IDLE) && ack_rise;
  assign auto_clr = (ack_st == ACK_TWO) && ack_fall && aeoi_q && !spur_q;

  always_comb begin
    isr_n = isr_q;
    if (eoi_spec)            isr_n[eoi_lvl] = 1'b0;
    if (eoi_any && isr_any)  isr_n[isr_low] = 1'b0;
    if (take && any_elig)    isr_n[win_lvl] = 1'b1;
    if (auto_clr)            isr_n[lvl_q]   = 1'b0;
    if (init_go)             isr_n          = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      ack_st <= ACK_IDLE;
      lvl_q  <= '0;
      spur_q <= 1'b0;
      isr_q  <= '0;
    end else begin
      ack_q <= int_ack;
      isr_q <= isr_n;
      unique case (ack_st)
        ACK_IDLE: if (ack_rise) begin
          ack_st <= ACK_ONE;
          lvl_q  <= any_elig ? win_lvl : '1;
          spur_q <= !any_elig;
        end
        ACK_ONE:  if (ack_rise) ack_st <= ACK_TWO;
        default:  if (ack_fall) ack_st <= ACK_IDLE;
      endcase
    end
  end

  assign int_out   = any_elig;
  assign vec_valid = (ack_st == ACK_TWO);
  assign vec_out   = {base_hi, lvl_q};
  assign reg_rdata = reg_addr ? imr_q : (rd_isr ? isr_q : irr_q);
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int unsigned NUM_IRQ = 8,
  localparam int unsigned LVL_W = $clog2(NUM_IRQ)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_addr,
  input logic [NUM_IRQ-1:0] reg_wdata,
  input logic               int_ack,
  input logic               ack_q,
  input logic               int_out,
  input logic               vec_valid,
  input logic [NUM_IRQ-1:0] vec_out,
  input logic [NUM_IRQ-1:0] irr_q,
  input logic [NUM_IRQ-1:0] imr_q,
  input logic [NUM_IRQ-1:0] isr_q,
  input logic [1:0]         ack_st,
  input logic [LVL_W-1:0]   lvl_q,
  input logic               spur_q,
  input logic               aeoi_q
);
  p_int_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr_q & ~imr_q) != '0));

  p_vec_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> $past(int_ack));

  p_spur_lvl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && spur_q) |-> (vec_out[LVL_W-1:0] == {LVL_W{1'b1}}));

  p_init_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_wdata[4]) |=> (isr_q == '0 && irr_q == '0 && imr_q == '0));

  p_spec_eoi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_wdata[7:3] == 5'b01100 && !int_ack)
      |=> !isr_q[$past(reg_wdata[LVL_W-1:0])]);

  p_aeoi_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_st == 2'd2 && ack_q && !int_ack && aeoi_q && !spur_q && !reg_wr)
      |=> !isr_q[$past(lvl_q)]);
endmodule

bind prio_irq_ctrl pic_checker #(.NUM_IRQ(NUM_IRQ)) u_pic_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .int_ack  (int_ack),
  .ack_q    (ack_q),
  .int_out  (int_out),
  .vec_valid(vec_valid),
  .vec_out  (vec_out),
  .irr_q    (irr_q),
  .imr_q    (imr_q),
  .isr_q    (isr_q),
  .ack_st   (ack_st),
  .lvl_q    (lvl_q),
  .spur_q   (spur_q),
  .aeoi_q   (aeoi_q)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] irq_in = 8'h00;
  logic       int_out;
  logic       int_ack = 1'b0;
  logic       vec_valid;
  logic [7:0] vec_out;
  logic [7:0] cascade_cfg;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .int_out(int_out), .int_ack(int_ack), .vec_valid(vec_valid),
    .vec_out(vec_out), .cascade_cfg(cascade_cfg)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic do_ack(output logic [7:0] vec, output logic vv);
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk);
    vv = vec_valid; vec = vec_out;
    int_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 int_out", {7'd0, int_out}, 8'h00);
    chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
    rd(1'b1, d); chk("R1 mask", d, 8'hFF);
    rd(1'b0, d); chk("R1 irr", d, 8'h00);
  endtask

  task automatic t_init_full();
    logic [7:0] d;
    wr(1'b0, 8'h11); wr(1'b1, 8'h08); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd(1'b1, d); chk("R2 mask cleared", d, 8'h00);
    chk("R4 cascade", cascade_cfg, 8'h04);
  endtask

  task automatic t_basic();
    logic [7:0] d, v; logic vv;
    set_irq(8'h20);
    chk("R6 int_out on edge", {7'd0, int_out}, 8'h01);
    rd(1'b0, d); chk("R6 irr latched", d, 8'h20);
    do_ack(v, vv);
    chk("R8 vec_valid", {7'd0, vv}, 8'h01);
    chk("R3 vector", v, 8'h0D);
    rd(1'b0, d); chk("R6 irr cleared by ack", d, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R10 isr readback", d, 8'h20);
    wr(1'b0, 8'h20);
    rd(1'b0, d); chk("R12 eoi clears", d, 8'h00);
    set_irq(8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d, v; logic vv;
    set_irq(8'h44);
    do_ack(v, vv); chk("R7 lowest wins", v, 8'h0A);
    chk("R7 blocked by isr", {7'd0, int_out}, 8'h00);
    set_irq(8'h46);
    chk("R7 nesting int", {7'd0, int_out}, 8'h01);
    do_ack(v, vv); chk("R7 nested vector", v, 8'h09);
    rd(1'b0, d); chk("R8 isr nested", d, 8'h06);
    wr(1'b0, 8'h62);
    rd(1'b0, d); chk("R11 only bit 2", d, 8'h02);
    wr(1'b0, 8'h20);
    rd(1'b0, d); chk("R12 nonspecific", d, 8'h00);
    chk("R7 pending 6 free", {7'd0, int_out}, 8'h01);
    do_ack(v, vv); chk("R7 level 6", v, 8'h0E);
    wr(1'b0, 8'h66);
    rd(1'b0, d); chk("R11 clear 6", d, 8'h00);
    set_irq(8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d, v; logic vv;
    wr(1'b1, 8'h10);
    set_irq(8'h10);
    chk("R5 masked no int", {7'd0, int_out}, 8'h00);
    rd(1'b1, d); chk("R5 mask readback", d, 8'h10);
    wr(1'b0, 8'h0A);
    rd(1'b0, d); chk("R10 irr readback", d, 8'h10);
    wr(1'b1, 8'h00);
    chk("R5 unmasked int", {7'd0, int_out}, 8'h01);
    do_ack(v, vv); chk("R5 vector", v, 8'h0C);
    wr(1'b0, 8'h20);
    set_irq(8'h00);
  endtask

  task automatic t_spurious();
    logic [7:0] d, v; logic vv;
    set_irq(8'h08);
    set_irq(8'h00);
    chk("R6 withdrawn", {7'd0, int_out}, 8'h00);
    do_ack(v, vv); chk("R9 spurious vector", v, 8'h0F);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R9 isr untouched", d, 8'h00);
  endtask

  task automatic t_aeoi();
    logic [7:0] d, v; logic vv;
    wr(1'b0, 8'h13); wr(1'b1, 8'h20); wr(1'b1, 8'h03); wr(1'b1, 8'h80);
    rd(1'b1, d); chk("R2 short sequence mask", d, 8'h80);
    chk("R4 cascade kept", cascade_cfg, 8'h04);
    set_irq(8'h02);
    rd(1'b0, d); chk("R2 irr selected", d, 8'h02);
    do_ack(v, vv); chk("R3 new base", v, 8'h21);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R13 auto clear", d, 8'h00);
    set_irq(8'h00);
    set_irq(8'h80);
    set_irq(8'h00);
    do_ack(v, vv); chk("R9 spurious masked 7", v, 8'h27);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_full();
    t_basic();
    t_priority();
    t_mask();
    t_spurious();
    t_aeoi();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule